// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recently used page translations and answers lookups by content. Every stored virtual page number is compared against the page number of the presented virtual address at the same time. When one entry matches, the block returns the physical address: the stored frame number followed by the page offset, which passes through untouched. It also returns the entry's access rights and a fault flag when the requested kind of access is not allowed. No memory read is needed for a hit.

When nothing matches, the block raises a miss flag. An external walker then resolves the translation and writes it back through the fill port. A fill reuses the entry that already holds the same page number, otherwise the lowest free entry, otherwise the entry under a rotating victim pointer. A flush input drops every translation at once, so that a context switch cannot leave one address space's mappings visible to the next.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and the rotating victim pointer points at entry 0.
- R2: While `lk_req` is high exactly one of `lk_hit` and `lk_miss` is high in the same cycle, computed combinationally from `lk_vaddr`; while `lk_req` is low both are low.
- R3: On a hit `lk_paddr` equals the stored frame number in its upper 20 bits followed by `lk_vaddr[11:0]` unchanged; on a miss `lk_paddr` and `lk_perm` are zero.
- R4: A fill (`fill_en` high at a rising clock edge with `flush` low) installs the page number, frame number and rights, and lookups of that page hit from the next cycle; filling never reduces the number of valid entries.
- R5: A fill of a new page goes to the lowest-numbered invalid entry; when all entries are valid it replaces the entry under the victim pointer. The pointer advances by one, wrapping after the last entry, on every accepted fill.
- R6: A fill whose page number matches a valid entry overwrites that entry in place, so no two valid entries ever hold the same page number.
- R7: A flush at a rising edge invalidates every entry for the next cycle. A fill in the same cycle as a flush is discarded.
- R8: Rights bits are `[0]` read, `[1]` write, `[2]` execute, `[3]` user. `lk_kind` 0 and 3 need read, 1 needs write, 2 needs execute; with `lk_user` high the user bit is needed too. `lk_fault` is high only on a hit whose rights do not allow the access, and `lk_perm` shows the stored rights on a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| lk_user | input | 1 | Access made in user mode |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent, walk needed |
| lk_paddr | output | 32 | Physical address on a hit |
| lk_perm | output | 4 | Rights of the matching entry |
| lk_fault | output | 1 | Hit whose rights forbid the access |
| fill_en | input | 1 | Write a resolved translation |
| fill_vpn | input | 20 | Page number of the fill |
| fill_ppn | input | 20 | Frame number of the fill |
| fill_perm | input | 4 | Rights of the fill |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench fills the buffer with non-contiguous page numbers and then keeps filling, so that the victim pointer must have wrapped to entry 0 and then advance one step per fill; a design that forgot to advance on in-place updates would evict the wrong page, which shows as a hit on a page that should be gone and a miss on one that should remain. It refills a resident page with a new frame number, which a design that placed it in a fresh slot would answer with a stale or mixed frame. It asserts flush and fill together and expects both the old and the new page to miss, catching a design that lets the fill win. Rights checks combine read-only and user-restricted pages with each access kind, which exposes a swapped bit position as a wrong fault.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
    localparam int unsigned PERM_W = 4;
    localparam int unsigned PB_R = 0;
    localparam int unsigned PB_W = 1;
    localparam int unsigned PB_X = 2;
    localparam int unsigned PB_U = 3;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RD2   = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
// Parallel key compare: one comparator per entry.
module xlat_match #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned VPN_W   = 20
) (
    input  logic [VPN_W-1:0]              key,
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tab,
    output logic [ENTRIES-1:0]            match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] && (tab[g] == key);
    end
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
// Chooses the entry a fill writes: existing key, then lowest free, then pointer.
module xlat_victim #(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vld,
    input  logic [ENTRIES-1:0] dup,
    input  logic [IDX_W-1:0]   ptr,
    output logic [ENTRIES-1:0] sel
);
    logic found;

    always_comb begin
        sel   = '0;
        found = 1'b0;
        if (|dup) begin
            sel = dup;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!vld[i] && !found) begin
                    sel[i] = 1'b1;
                    found  = 1'b1;
                end
            end
            if (!found) begin
                sel[ptr] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlat_perm.sv
`timescale 1ns/1ps
// Rights check for the matching entry.
module xlat_perm
    import xlat_pkg::*;
(
    input  logic [PERM_W-1:0] perm,
    input  logic [1:0]        kind,
    input  logic              user,
    input  logic              hit,
    output logic              fault
);
    logic need_ok;

    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_WRITE: need_ok = perm[PB_W];
            ACC_EXEC:  need_ok = perm[PB_X];
            default:   need_ok = perm[PB_R];
        endcase
        fault = hit && !(need_ok && (!user || perm[PB_U]));
    end
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned PPN_W   = 20,
    parameter int unsigned OFF_W   = 12,
    localparam int unsigned VA_W   = VPN_W + OFF_W,
    localparam int unsigned PA_W   = PPN_W + OFF_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [1:0]        lk_kind,
    input  logic              lk_user,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [PERM_W-1:0] lk_perm,
    output logic              lk_fault,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              flush
);
    typedef struct packed {
        logic              vld;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0] tab;
        logic [IDX_W-1:0]   ptr;
    } st_t;

    st_t st_d, st_q;

    logic [ENTRIES-1:0]            vld_vec;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_tab;
    logic [ENTRIES-1:0]            lk_match;
    logic [ENTRIES-1:0]            fill_match;
    logic [ENTRIES-1:0]            fill_sel;
    logic [PPN_W-1:0]              sel_ppn;
    logic [PERM_W-1:0]             sel_perm;
    logic                          any_hit;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            vld_vec[i] = st_q.tab[i].vld;
            vpn_tab[i] = st_q.tab[i].vpn;
        end
    end

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_lk_match (
        .key  (lk_vaddr[VA_W-1:OFF_W]),
        .vld  (vld_vec),
        .tab  (vpn_tab),
        .match(lk_match)
    );

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) i_fill_match (
        .key  (fill_vpn),
        .vld  (vld_vec),
        .tab  (vpn_tab),
        .match(fill_match)
    );

    xlat_victim #(.ENTRIES(ENTRIES)) i_victim (
        .vld(vld_vec),
        .dup(fill_match),
        .ptr(st_q.ptr),
        .sel(fill_sel)
    );

    // Lookup result: OR-select over the (at most one-hot) match vector.
    always_comb begin
        sel_ppn  = '0;
        sel_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                sel_ppn  = sel_ppn | st_q.tab[i].ppn;
                sel_perm = sel_perm | st_q.tab[i].perm;
            end
        end
        any_hit  = |lk_match;
        lk_hit   = lk_req && any_hit;
        lk_miss  = lk_req && !any_hit;
        lk_paddr = lk_hit ? {sel_ppn, lk_vaddr[OFF_W-1:0]} : '0;
        lk_perm  = lk_hit ? sel_perm : '0;
    end

    xlat_perm i_perm (
        .perm (lk_perm),
        .kind (lk_kind),
        .user (lk_user),
        .hit  (lk_hit),
        .fault(lk_fault)
    );

    // Next state: flush wins over fill.
    always_comb begin
        st_d = st_q;
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.tab[i].vld = 1'b0;
            end
        end else if (fill_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fill_sel[i]) begin
                    st_d.tab[i] = '{vld: 1'b1, vpn: fill_vpn, ppn: fill_ppn, perm: fill_perm};
                end
            end
            st_d.ptr = (st_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.ptr + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r2_one_of_two: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> (lk_hit != lk_miss));
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> (!lk_hit && !lk_miss));
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
    a_r4_fill_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> ($countones(vld_vec) >= $countones($past(vld_vec))));
    a_r6_unique_key: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_vec == '0));
    a_r8_fault_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);
endmodule

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_user = 1'b0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [31:0] lk_paddr;
    logic [3:0]  lk_perm;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [3:0]  fill_perm = '0;
    logic        flush = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic        hit;
        logic        miss;
        logic        fault;
        logic [31:0] pa;
        logic [3:0]  perm;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    xlat_cache i_xlat_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
        .lk_fault(lk_fault),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .flush(flush)
    );

    function automatic logic [19:0] vp(input int i);
        return 20'h12340 + 20'(i) * 20'h111;
    endfunction

    function automatic logic [19:0] pp(input int i);
        return 20'h80000 + 20'(i) * 20'h3;
    endfunction

    task automatic look(input logic [19:0] vpn, input logic [11:0] off,
                        input logic [1:0] kind, input logic user,
                        input logic eh, input logic [19:0] eppn,
                        input logic [3:0] eperm, input logic ef, input string tag);
        exp_t e;
        @(negedge clk);
        lk_req   = 1'b1;
        lk_vaddr = {vpn, off};
        lk_kind  = kind;
        lk_user  = user;
        e.hit   = eh;
        e.miss  = !eh;
        e.fault = ef;
        e.pa    = eh ? {eppn, off} : 32'h0;
        e.perm  = eh ? eperm : 4'h0;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        lk_req = 1'b0;
        e.hit = 1'b0; e.miss = 1'b0; e.fault = 1'b0; e.pa = '0; e.perm = '0;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic [3:0] perm, input logic fl);
        @(negedge clk);
        lk_req    = 1'b0;
        fill_en   = 1'b1;
        fill_vpn  = vpn;
        fill_ppn  = ppn;
        fill_perm = perm;
        flush     = fl;
        @(posedge clk);
        #1;
        fill_en = 1'b0;
        flush   = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        lk_req = 1'b0;
        flush  = 1'b1;
        @(posedge clk);
        #1;
        flush = 1'b0;
    endtask

    // Monitor: pops one expectation per cycle, mid low phase.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (lk_hit !== e.hit || lk_miss !== e.miss || lk_fault !== e.fault ||
                    lk_paddr !== e.pa || lk_perm !== e.perm) begin
                    n_bad++;
                    $display("FAIL %s: got hit=%b miss=%b fault=%b pa=%h perm=%h, exp hit=%b miss=%b fault=%b pa=%h perm=%h",
                             e.tag, lk_hit, lk_miss, lk_fault, lk_paddr, lk_perm,
                             e.hit, e.miss, e.fault, e.pa, e.perm);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset
        look(vp(0), 12'h000, 2'd0, 1'b0, 1'b0, '0, '0, 1'b0, "R1 reset miss v0");
        look(20'h00000, 12'hFFF, 2'd0, 1'b0, 1'b0, '0, '0, 1'b0, "R1 reset miss zero page");
        // R2: no request, no flags
        idle("R2 idle");

        // R4/R5: fill eight non-contiguous pages into the empty buffer
        for (int i = 0; i < 8; i++) begin
            fill(vp(i), pp(i), (i == 5) ? 4'b0101 : 4'b1111, 1'b0);
        end
        for (int i = 0; i < 8; i++) begin
            look(vp(i), 12'(i * 12'h1A3), 2'd0, 1'b0, 1'b1, pp(i),
                 (i == 5) ? 4'b0101 : 4'b1111, 1'b0, "R3 R4 hit after fill");
        end

        // R8: rights, entry 5 = read+exec only
        look(vp(5), 12'h010, 2'd1, 1'b0, 1'b1, pp(5), 4'b0101, 1'b1, "R8 write to read-only");
        look(vp(5), 12'h020, 2'd2, 1'b0, 1'b1, pp(5), 4'b0101, 1'b0, "R8 exec allowed");
        look(vp(5), 12'h030, 2'd3, 1'b1, 1'b1, pp(5), 4'b0101, 1'b1, "R8 user on kernel page");
        look(vp(0), 12'h040, 2'd1, 1'b1, 1'b1, pp(0), 4'b1111, 1'b0, "R8 user write allowed");
        look(20'hFFFFF, 12'h050, 2'd1, 1'b0, 1'b0, '0, '0, 1'b0, "R8 no fault on miss");

        // R5: full, pointer wrapped to 0
        fill(20'hA0001, 20'h11111, 4'b1111, 1'b0);
        look(vp(0), 12'h000, 2'd0, 1'b0, 1'b0, '0, '0, 1'b0, "R5 slot0 evicted");
        look(20'hA0001, 12'h123, 2'd0, 1'b0, 1'b1, 20'h11111, 4'b1111, 1'b0, "R5 new page hit");
        fill(20'hA0002, 20'h22222, 4'b0011, 1'b0);
        look(vp(1), 12'h000, 2'd0, 1'b0, 1'b0, '0, '0, 1'b0, "R5 slot1 evicted");
        look(vp(2), 12'h7FF, 2'd0, 1'b0, 1'b1, pp(2), 4'b1111, 1'b0, "R5 slot2 kept");

        // R6: in-place update of resident page, pointer still advances
        fill(vp(2), 20'hABCDE, 4'b1001, 1'b0);
        look(vp(2), 12'h456, 2'd0, 1'b0, 1'b1, 20'hABCDE, 4'b1001, 1'b0, "R6 updated in place");
        fill(20'hA0003, 20'h33333, 4'b1111, 1'b0);
        look(vp(3), 12'h000, 2'd0, 1'b0, 1'b0, '0, '0, 1'b0, "R5 R6 slot3 evicted after update");
        look(vp(2), 12'h001, 2'd0, 1'b0, 1'b1, 20'hABCDE, 4'b1001, 1'b0, "R6 updated page kept");
        look(vp(4), 12'h002, 2'd0, 1'b0, 1'b1, pp(4), 4'b1111, 1'b0, "R5 slot4 kept");

        // R7: flush and fill together, flush wins
        fill(20'hB0000, 20'h44444, 4'b1111, 1'b1);
        look(20'hB0000, 12'h000, 2'd0, 1'b0, 1'b0, '0, '0, 1'b0, "R7 fill dropped by flush");
        look(vp(4), 12'h000, 2'd0, 1'b0, 1'b0, '0, '0, 1'b0, "R7 old entry flushed");
        look(20'hA0001, 12'h000, 2'd0, 1'b0, 1'b0, '0, '0, 1'b0, "R7 newer entry flushed");

        // R7: plain flush after a fill
        fill(20'hC0000, 20'h55555, 4'b1111, 1'b0);
        look(20'hC0000, 12'hABC, 2'd0, 1'b0, 1'b1, 20'h55555, 4'b1111, 1'b0, "R4 fill after flush");
        do_flush();
        look(20'hC0000, 12'hABC, 2'd0, 1'b0, 1'b0, '0, '0, 1'b0, "R7 flush alone");
        idle("R2 idle at end");

        @(negedge clk);
        #8;
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule